// File: doc/BRIEF.md
# Jamming 128-bit Right Shifter

This block shifts a 128-bit value right by a variable amount and folds every bit that falls off the bottom into the least significant bit of the result. It is meant for the alignment step of a floating-point adder or fused multiply-add. In those units the smaller operand is moved right until its exponent matches the larger one. The bits it loses must still count toward the inexact and rounding decisions. The single jammed bit carries that information, and no separate sticky output exists.

The value enters as two halves of `HALF_W` bits each, and the shift amount is a `CNT_W`-bit count. A small decoder sorts the count into one of four ranges: pass-through, short, cross-half and over-range. A lane unit then applies the formula for that range. When `OUT_REG` is 1, an output stage registers the result together with a valid bit. When `OUT_REG` is 0, the result and the valid bit pass straight through.

Top module: `sticky_rshift128`

## Requirements
- R1: A count of 0 returns both halves unchanged, with no bit forced into the LSB.
- R2: For counts 1 to 63, the high half is the old high half shifted right logically by the count, and the low half takes the old low half shifted right with the old high half's low bits moving in above it.
- R3: For counts 1 to 63, result bit 0 is additionally ORed with the OR of the low-half bits shifted out (old low bits 0 to count-1).
- R4: For a count of exactly 64, the high half becomes zero and the low half becomes the old high half, with bit 0 ORed with the OR of the entire old low half.
- R5: For counts 65 to 127, the high half becomes zero. The low half is the old high half shifted right by count-64, and its bit 0 is ORed with the lost high-half bits and with every bit of the old low half.
- R6: Any count from 128 to 255 (8-bit count input) yields a zero high half. The low half is 1 when any input bit was set and 0 otherwise.
- R7: A nonzero input never produces an all-zero result, whatever the count.
- R8: With the output register enabled, the result and `out_valid` appear one clock after `in_valid` and the data were presented. Reset clears `out_valid` and the output data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input qualifier |
| in_hi | input | 64 | Upper half of the value |
| in_lo | input | 64 | Lower half of the value |
| shamt | input | 8 | Right shift count |
| out_valid | output | 1 | Result qualifier |
| out_hi | output | 64 | Upper half of the shifted value |
| out_lo | output | 64 | Lower half of the shifted value, sticky jammed into bit 0 |

## Verification
In the default configuration every result and its valid bit are due exactly one rising edge after the inputs are applied. The bench drives a new vector on each falling edge and compares the outputs on the next falling edge. By then the register has captured that vector and the next one has not yet been clocked in. One extra idle cycle with `in_valid` low confirms that `out_valid` drops on the following edge. The expected value comes from a 256-bit widened shift, with sticky taken as the reduction OR of the bits masked below the count.

// File: rtl/srsh_pkg.sv
package srsh_pkg;
  typedef enum logic [1:0] {
    SH_PASS  = 2'd0,
    SH_SMALL = 2'd1,
    SH_MID   = 2'd2,
    SH_OVER  = 2'd3
  } sh_range_e;
endpackage

// File: rtl/srsh_range_dec.sv
module srsh_range_dec
  import srsh_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  output sh_range_e        rng_o,
  output logic [CNT_W-1:0] amt_o
);
  localparam logic [CNT_W:0]   FULL_C = (CNT_W+1)'(2 * HALF_W);
  localparam logic [CNT_W:0]   HALF_X = (CNT_W+1)'(HALF_W);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF_W);

  logic [CNT_W:0] cnt_x;
  assign cnt_x = {1'b0, cnt_i};

  always_comb begin
    amt_o = cnt_i;
    if (cnt_x >= FULL_C) begin
      rng_o = SH_OVER;
    end else if (cnt_x >= HALF_X) begin
      rng_o = SH_MID;
      amt_o = cnt_i - HALF_C;
    end else if (cnt_i != '0) begin
      rng_o = SH_SMALL;
    end else begin
      rng_o = SH_PASS;
    end
  end
endmodule

// File: rtl/srsh_lanes.sv
module srsh_lanes
  import srsh_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int CNT_W  = 8
) (
  input  sh_range_e         rng_i,
  input  logic [CNT_W-1:0]  amt_i,
  input  logic [HALF_W-1:0] hi_i,
  input  logic [HALF_W-1:0] lo_i,
  output logic [HALF_W-1:0] hi_o,
  output logic [HALF_W-1:0] lo_o,
  output logic              lost_o
);
  localparam logic [HALF_W-1:0] ONES = '1;

  // OR of the bits of v below position n
  function automatic logic lost_below(logic [HALF_W-1:0] v, logic [CNT_W-1:0] n);
    return |(v & ~(ONES << n));
  endfunction

  logic [HALF_W-1:0] lo_raw;

  always_comb begin
    hi_o   = hi_i;
    lo_raw = lo_i;
    lost_o = 1'b0;
    case (rng_i)
      SH_PASS: begin
      end
      SH_SMALL: begin
        {hi_o, lo_raw} = {hi_i, lo_i} >> amt_i;
        lost_o         = lost_below(lo_i, amt_i);
      end
      SH_MID: begin
        hi_o   = '0;
        lo_raw = hi_i >> amt_i;
        lost_o = lost_below(hi_i, amt_i) | (|lo_i);
      end
      SH_OVER: begin
        hi_o   = '0;
        lo_raw = '0;
        lost_o = |{hi_i, lo_i};
      end
      default: begin
        hi_o   = '0;
        lo_raw = '0;
      end
    endcase
    lo_o    = lo_raw;
    lo_o[0] = lo_raw[0] | lost_o;
  end
endmodule

// File: rtl/srsh_stage.sv
module srsh_stage #(
  parameter int W       = 128,
  parameter bit OUT_REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         vld_o,
  output logic [W-1:0] d_o
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_o <= 1'b0;
          d_o   <= '0;
        end else begin
          vld_o <= vld_i;
          d_o   <= d_i;
        end
      end
    end else begin : g_wire
      assign vld_o = vld_i;
      assign d_o   = d_i;
    end
  endgenerate
endmodule

// File: rtl/sticky_rshift128.sv
module sticky_rshift128
  import srsh_pkg::*;
#(
  parameter int HALF_W  = 64,
  parameter int CNT_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [HALF_W-1:0] in_hi,
  input  logic [HALF_W-1:0] in_lo,
  input  logic [CNT_W-1:0]  shamt,
  output logic              out_valid,
  output logic [HALF_W-1:0] out_hi,
  output logic [HALF_W-1:0] out_lo
);
  localparam int             FULL_W = 2 * HALF_W;
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF_W);

  sh_range_e         rng_w;
  logic [CNT_W-1:0]  amt_w;
  logic [HALF_W-1:0] comb_hi, comb_lo;
  logic              lost_w;

  srsh_range_dec #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_dec (
    .cnt_i (shamt),
    .rng_o (rng_w),
    .amt_o (amt_w)
  );

  srsh_lanes #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_lanes (
    .rng_i  (rng_w),
    .amt_i  (amt_w),
    .hi_i   (in_hi),
    .lo_i   (in_lo),
    .hi_o   (comb_hi),
    .lo_o   (comb_lo),
    .lost_o (lost_w)
  );

  logic [FULL_W-1:0] out_bus;

  srsh_stage #(.W(FULL_W), .OUT_REG(OUT_REG)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (in_valid),
    .d_i   ({comb_hi, comb_lo}),
    .vld_o (out_valid),
    .d_o   (out_bus)
  );

  assign out_hi = out_bus[FULL_W-1:HALF_W];
  assign out_lo = out_bus[HALF_W-1:0];

  // named events for the checks
  logic in_nonzero_w, res_nonzero_w;
  assign in_nonzero_w  = |{in_hi, in_lo};
  assign res_nonzero_w = |{comb_hi, comb_lo};

  assert_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shamt == '0) |-> ({comb_hi, comb_lo} == {in_hi, in_lo}));

  assert_exact_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && shamt == HALF_C) |->
      (comb_hi == '0 && comb_lo[HALF_W-1:1] == in_hi[HALF_W-1:1]));

  assert_mid_hi_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rng_w == SH_MID) |-> (comb_hi == '0));

  assert_over_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rng_w == SH_OVER) |->
      (comb_hi == '0 && comb_lo[HALF_W-1:1] == '0 && comb_lo[0] == in_nonzero_w));

  assert_no_vanish_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_nonzero_w) |-> res_nonzero_w);

  generate
    if (OUT_REG) begin : g_lat_chk
      assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid && out_hi == $past(comb_hi) && out_lo == $past(comb_lo)));
      assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    end
  endgenerate
endmodule

// File: tb/sticky_rshift128_bench.sv
module sticky_rshift128_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [63:0]  in_hi = '0;
  logic [63:0]  in_lo = '0;
  logic [7:0]   shamt = '0;
  logic         out_valid;
  logic [63:0]  out_hi, out_lo;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk; // 50 MHz

  sticky_rshift128 u_sticky_rshift128 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_hi(in_hi), .in_lo(in_lo), .shamt(shamt),
    .out_valid(out_valid), .out_hi(out_hi), .out_lo(out_lo)
  );

  // reference: widen to 256 bits, shift, sticky = OR of masked-off bits
  function automatic logic [127:0] ref_shift(logic [127:0] v, logic [7:0] c);
    logic [255:0] ext, sh, mask;
    logic         lost;
    logic [127:0] r;
    ext  = {128'b0, v};
    sh   = ext >> c;
    mask = (256'b1 << c) - 256'b1;
    lost = |(ext & mask);
    r    = sh[127:0];
    r[0] = r[0] | lost;
    return r;
  endfunction

  function automatic string tag_for(logic [7:0] c);
    if (c == 8'd0)       return "R1";
    else if (c < 8'd64)  return "R2/R3";
    else if (c == 8'd64) return "R4";
    else if (c < 8'd128) return "R5";
    else                 return "R6";
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp_v);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  task automatic apply(logic [127:0] v, logic [7:0] c);
    logic [127:0] e;
    @(negedge clk);
    in_valid = 1'b1;
    {in_hi, in_lo} = v;
    shamt = c;
    e = ref_shift(v, c);
    @(negedge clk);
    check("R8 valid", {127'b0, out_valid}, 128'd1);
    check(tag_for(c), {out_hi, out_lo}, e);
    if (v != '0)
      check("R7 nonzero", {127'b0, |{out_hi, out_lo}}, 128'd1);
  endtask

  function automatic logic [63:0] xs64(logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        tests++;
        fails++;
        $display("FAIL watchdog act=%0d exp<=100000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [63:0]  seed;
    logic [127:0] pat;
    repeat (3) @(negedge clk);
    check("R8 reset valid", {127'b0, out_valid}, 128'd0);
    check("R8 reset data", {out_hi, out_lo}, 128'd0);
    rst_n = 1'b1;

    seed = 64'h9E37_79B9_7F4A_7C15;
    for (int p = 0; p < 16; p++) begin
      case (p)
        0:  pat = '1;
        1:  pat = 128'd0;
        2:  pat = 128'd1;
        3:  pat = 128'd1 << 1;
        4:  pat = 128'd1 << 31;
        5:  pat = 128'd1 << 63;
        6:  pat = 128'd1 << 64;
        7:  pat = 128'd1 << 65;
        8:  pat = 128'd1 << 100;
        9:  pat = 128'd1 << 127;
        default: begin
          seed = xs64(seed);
          pat[127:64] = seed;
          seed = xs64(seed);
          pat[63:0] = seed;
        end
      endcase
      for (int c = 0; c < 256; c++) apply(pat, 8'(c));
    end

    // idle cycle: valid must drop one edge later
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 idle", {127'b0, out_valid}, 128'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule